// File: doc/BRIEF.md
# Reed-Muller Deterministic Test Generator

This block generates a fixed and universal stimulus sequence for a positive-polarity AND-EXOR network. The network has `N_IN` data inputs and one extra control input that sits at the head of its EXOR cascade. A start pulse launches the sequence. The block then presents one vector per enabled cycle on an `N_IN+1`-bit bus with a valid flag. When the sequence is complete it pulses `done`. The sequence is identical for every network of a given input count, and it covers every single stuck-at fault. That makes the block suitable as the stimulus half of a built-in self-test arrangement.

There are two parts to the sequence. A head of four vectors combines both control values with all-zero and all-one data. A walking-zero pass follows, with one vector per data input. No seed is loaded and nothing needs initializing beyond reset. The head comes from a two-bit phase counter and the walking pattern from an `N_IN`-bit one-hot shifter, so area grows linearly with the input count.

Top module: `rmtg_gen`

## Requirements
- R1: While reset is high and in the cycles after it, `vec_valid` and `done` are 0 and `vec` is all zero, until a start is accepted.
- R2: A `start` seen in idle makes `vec_valid` 1 on the next cycle with vector 0 on `vec`, whatever `enable` is.
- R3: Vector `vec[0]` carries the control input and `vec[k]` (k = 1..N_IN) carries data input k. The head vectors 0..3 are, in order: control 0 / data all 0; control 0 / data all 1; control 1 / data all 0; control 1 / data all 1.
- R4: Vector 4+j (j = 0..N_IN-1) has data bit `vec[j+1]` at 0 and every other data bit at 1.
- R5: During the walking-zero vectors, `vec[0]` equals parameter `WALK_X0`.
- R6: A run presents exactly N_IN+4 distinct valid vectors. The cycle after the last one is consumed with `enable` high, `done` is 1 for exactly one cycle with `vec_valid` at 0, and the block then returns to idle.
- R7: While `vec_valid` is 1 and `enable` is 0, the next cycle shows the same vector, still valid.
- R8: A `start` while a run is in progress, or in the `done` cycle, has no effect on the vectors or their order.
- R9: A `start` after a completed run begins again at vector 0.
- R10: Reset during a run returns the block to idle at once, with `vec_valid` at 0.
- R11: Whenever `vec_valid` is 0, `vec` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a run when idle |
| enable | input | 1 | Advances to the next vector when high |
| vec | output | N_IN+1 | Test vector: bit 0 control input, bits 1..N_IN data inputs |
| vec_valid | output | 1 | `vec` holds a vector of the current run |
| done | output | 1 | One-cycle pulse after the last vector |

## Verification
The hardest situations to reach from the ports are a start that lands exactly on the `done` cycle, and a reset that cuts a walking-zero pass partway through. Both need the run to be at a precise position when the stimulus arrives. Random start and enable streams run for long stretches, with a thin sprinkling of resets, against a bench-side model that tracks the run position. Across hundreds of short runs this produces starts on every phase, including the done cycle, and resets inside both groups. The runs cover input counts of 1, 5 and 9, with both settings of the walking control value.

// File: rtl/rmtg_pkg.sv
package rmtg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_WALK = 2'd2,
    ST_DONE = 2'd3
  } rmtg_state_e;

  localparam int HEAD_LEN = 4;

  // control input value for a head phase: upper half of the head uses 1
  function automatic logic head_ctrl(input logic [1:0] phase);
    return (phase >= 2'd2);
  endfunction

  // data fill for a head phase: odd phases use all ones
  function automatic logic head_data(input logic [1:0] phase);
    return (phase == 2'd1) || (phase == 2'd3);
  endfunction

  // total number of vectors in a run
  function automatic int run_length(input int n_in);
    return n_in + HEAD_LEN;
  endfunction

endpackage

// File: rtl/rmtg_phase_ctr.sv
module rmtg_phase_ctr #(
  parameter int PHASES = 4,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          adv,
  output logic [PW-1:0] phase,
  output logic          last
);
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || clear) phase_q <= '0;
    else if (adv) begin
      if (phase_q == PW'(PHASES - 1)) phase_q <= '0;
      else phase_q <= phase_q + 1'b1;
    end
  end

  assign phase = phase_q;
  assign last  = (phase_q == PW'(PHASES - 1));

  AST_PHASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clear |=> phase == '0); // R2

endmodule

// File: rtl/rmtg_walk_reg.sv
module rmtg_walk_reg #(
  parameter int N_IN = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            shift,
  input  logic            clear,
  output logic [N_IN-1:0] hot,
  output logic            at_end
);
  logic [N_IN-1:0] hot_q;
  logic [N_IN-1:0] hot_shifted;

  generate
    if (N_IN == 1) begin : g_single
      assign hot_shifted = '0;
    end else begin : g_multi
      assign hot_shifted = {hot_q[N_IN-2:0], 1'b0};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) hot_q <= '0;
    else if (load)    hot_q <= N_IN'(1);
    else if (shift)   hot_q <= hot_shifted;
  end

  assign hot    = hot_q;
  assign at_end = hot_q[N_IN-1];

  AST_WALK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hot)); // R4

  AST_WALK_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
    load && !clear |=> hot[0]); // R4

endmodule

// File: rtl/rmtg_seq_ctrl.sv
module rmtg_seq_ctrl
  import rmtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        enable,
  input  logic        head_last,
  input  logic        walk_last,
  output rmtg_state_e st,
  output logic        ev_accept,
  output logic        ev_head_adv,
  output logic        ev_enter_walk,
  output logic        ev_walk_adv,
  output logic        ev_finish
);
  rmtg_state_e st_q, st_d;

  always_comb begin
    st_d          = st_q;
    ev_accept     = 1'b0;
    ev_head_adv   = 1'b0;
    ev_enter_walk = 1'b0;
    ev_walk_adv   = 1'b0;
    ev_finish     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d      = ST_HEAD;
          ev_accept = 1'b1;
        end
      end
      ST_HEAD: begin
        if (enable) begin
          ev_head_adv = 1'b1;
          if (head_last) begin
            st_d          = ST_WALK;
            ev_enter_walk = 1'b1;
          end
        end
      end
      ST_WALK: begin
        if (enable) begin
          if (walk_last) begin
            st_d      = ST_DONE;
            ev_finish = 1'b1;
          end else begin
            ev_walk_adv = 1'b1;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign st = st_q;

  AST_DONE_LEAVES: assert property (@(posedge clk) disable iff (rst)
    st == ST_DONE |=> st == ST_IDLE); // R6

  AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WALK) && start && !enable |=> st == ST_WALK); // R8

endmodule

// File: rtl/rmtg_vec_mux.sv
module rmtg_vec_mux
  import rmtg_pkg::*;
#(
  parameter int N_IN    = 5,
  parameter bit WALK_X0 = 1'b0
) (
  input  rmtg_state_e     st,
  input  logic [1:0]      phase,
  input  logic [N_IN-1:0] hot,
  output logic [N_IN:0]   vec
);
  logic head_on;
  logic walk_on;
  logic fill;

  assign head_on = (st == ST_HEAD);
  assign walk_on = (st == ST_WALK);
  assign fill    = head_data(phase);

  always_comb begin
    if (head_on)      vec[0] = head_ctrl(phase);
    else if (walk_on) vec[0] = WALK_X0;
    else              vec[0] = 1'b0;
  end

  genvar g;
  generate
    for (g = 0; g < N_IN; g++) begin : g_data
      assign vec[g+1] = head_on ? fill : (walk_on & ~hot[g]);
    end
  endgenerate

endmodule

// File: rtl/rmtg_gen.sv
module rmtg_gen
  import rmtg_pkg::*;
#(
  parameter int N_IN    = 5,
  parameter bit WALK_X0 = 1'b0,
  localparam int VW     = N_IN + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          enable,
  output logic [VW-1:0] vec,
  output logic          vec_valid,
  output logic          done
);
  rmtg_state_e     st;
  logic            ev_accept, ev_head_adv, ev_enter_walk, ev_walk_adv, ev_finish;
  logic [1:0]      phase;
  logic            head_last;
  logic [N_IN-1:0] hot;
  logic            walk_last;

  rmtg_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .enable       (enable),
    .head_last    (head_last),
    .walk_last    (walk_last),
    .st           (st),
    .ev_accept    (ev_accept),
    .ev_head_adv  (ev_head_adv),
    .ev_enter_walk(ev_enter_walk),
    .ev_walk_adv  (ev_walk_adv),
    .ev_finish    (ev_finish)
  );

  rmtg_phase_ctr #(.PHASES(HEAD_LEN)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .clear(ev_accept),
    .adv  (ev_head_adv),
    .phase(phase),
    .last (head_last)
  );

  rmtg_walk_reg #(.N_IN(N_IN)) u_walk (
    .clk   (clk),
    .rst   (rst),
    .load  (ev_enter_walk),
    .shift (ev_walk_adv),
    .clear (ev_finish),
    .hot   (hot),
    .at_end(walk_last)
  );

  rmtg_vec_mux #(.N_IN(N_IN), .WALK_X0(WALK_X0)) u_mux (
    .st   (st),
    .phase(phase),
    .hot  (hot),
    .vec  (vec)
  );

  assign vec_valid = (st == ST_HEAD) || (st == ST_WALK);
  assign done      = (st == ST_DONE);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !vec_valid && !done); // R1

  AST_ACCEPT_FIRST: assert property (@(posedge clk) disable iff (rst)
    !vec_valid && !done && start |=> vec_valid && vec == '0); // R2

  AST_WALK_ONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    st == ST_WALK |-> $countones(vec[VW-1:1]) == N_IN - 1); // R4

  AST_WALK_CTRL: assert property (@(posedge clk) disable iff (rst)
    st == ST_WALK |-> vec[0] == WALK_X0); // R5

  AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    done |-> !vec_valid); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    vec_valid && !enable |=> vec_valid && $stable(vec)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |-> vec == '0); // R11

endmodule

// File: tb/rmtg_gen_tb_lane.sv
module rmtg_gen_tb_lane #(
  parameter int          N_IN        = 5,
  parameter bit          WALK_X0     = 1'b0,
  parameter int unsigned SEED        = 1,
  parameter int          RAND_CYCLES = 1500
) (
  input  logic clk,
  output int   checks,
  output int   fails,
  output logic finished
);
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          enable = 1'b0;
  logic [N_IN:0] vec;
  logic          vec_valid;
  logic          done;

  rmtg_gen #(.N_IN(N_IN), .WALK_X0(WALK_X0)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .enable   (enable),
    .vec      (vec),
    .vec_valid(vec_valid),
    .done     (done)
  );

  int    mst;      // 0 idle, 1 running, 2 done
  int    midx;
  bit    rs;       // a completed run just ended
  string ntag;
  int    obs_cnt;
  bit    prev_vv;
  bit    prev_e;

  // expected vector at run position idx, built bit by bit
  function automatic logic [N_IN:0] ref_vec(input int idx);
    logic [N_IN:0] v;
    v = '0;
    if (idx < 4) begin
      v[0] = (idx >= 2);
      for (int b = 1; b <= N_IN; b++) v[b] = (idx % 2 == 1);
    end else begin
      v[0] = WALK_X0;
      for (int b = 1; b <= N_IN; b++) v[b] = (b != idx - 3);
    end
    return v;
  endfunction

  task automatic report(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s N=%0d %s actual=%0h expected=%0h", tag, N_IN, what, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit s, input bit e);
    logic [N_IN:0] ev;
    string tag;
    ev = (mst == 1) ? ref_vec(midx) : '0;
    if (ntag != "") tag = ntag;
    else if (mst == 2) tag = "R6";
    else if (mst == 1) tag = (midx < 4) ? "R3" : "R4";
    else tag = "R11";
    ntag = "";
    report(tag, "vec", int'(vec), int'(ev));
    report(tag, "vec_valid", int'(vec_valid), (mst == 1) ? 1 : 0);
    report(tag, "done", int'(done), (mst == 2) ? 1 : 0);
    if (mst == 1 && midx >= 4) report("R5", "ctrl bit", int'(vec[0]), int'(WALK_X0));
    // count distinct vectors seen at the ports
    if (vec_valid && (!prev_vv || prev_e)) obs_cnt++;
    if (done) begin
      report("R6", "vectors per run", obs_cnt, N_IN + 4);
      obs_cnt = 0;
    end else if (!vec_valid) obs_cnt = 0;
    prev_vv = vec_valid;
    rst = r; start = s; enable = e;
    prev_e = e && !r;
    if (r) begin
      ntag = (mst != 0) ? "R10" : "R1";
      mst = 0; midx = 0; rs = 0;
    end else begin
      case (mst)
        0: if (s) begin
             ntag = rs ? "R9" : "R2";
             rs = 0; mst = 1; midx = 0;
           end
        1: begin
             if (!e) ntag = s ? "R8" : "R7";
             else begin
               if (s) ntag = "R8";
               if (midx == N_IN + 3) mst = 2;
               else midx++;
             end
           end
        default: begin
             if (s) ntag = "R8";
             mst = 0; rs = 1;
           end
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(SEED));
    checks = 0; fails = 0; finished = 1'b0;
    mst = 0; midx = 0; rs = 0; ntag = "R1";
    obs_cnt = 0; prev_vv = 0; prev_e = 0;
    @(negedge clk);
    step(1, 0, 0);
    step(0, 0, 0);
    // full run with starts sprinkled in while busy
    step(0, 1, 1);
    for (int k = 0; k < N_IN + 6; k++) step(0, (k % 3) == 0, 1);
    // holding with enable low, with and without a busy start
    step(0, 1, 0); step(0, 0, 0); step(0, 0, 1); step(0, 1, 0); step(0, 0, 1);
    step(0, 0, 0);
    // reset cutting a run
    step(1, 0, 0); step(0, 0, 0);
    // run to completion and restart straight after done
    step(0, 1, 1);
    for (int k = 0; k < N_IN + 4; k++) step(0, 0, 1);
    step(0, 1, 1);
    step(0, 1, 1);
    for (int k = 0; k < RAND_CYCLES; k++)
      step(($urandom % 250) == 0, ($urandom % 5) == 0, ($urandom % 4) != 0);
    for (int k = 0; k < N_IN + 8; k++) step(0, 0, 1);
    finished = 1'b1;
  end

endmodule

// File: tb/rmtg_gen_tb_top.sv
module rmtg_gen_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int   c0, c1, c2, f0, f1, f2;
  logic d0, d1, d2;

  rmtg_gen_tb_lane #(.N_IN(5), .WALK_X0(1'b0), .SEED(11)) lane_n5 (
    .clk(clk), .checks(c0), .fails(f0), .finished(d0));
  rmtg_gen_tb_lane #(.N_IN(1), .WALK_X0(1'b1), .SEED(22)) lane_n1 (
    .clk(clk), .checks(c1), .fails(f1), .finished(d1));
  rmtg_gen_tb_lane #(.N_IN(9), .WALK_X0(1'b1), .SEED(33)) lane_n9 (
    .clk(clk), .checks(c2), .fails(f2), .finished(d2));

  initial begin
    int cyc;
    int tot_c;
    int tot_f;
    cyc = 0;
    #1;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    tot_c = c0 + c1 + c2;
    tot_f = f0 + f1 + f2;
    if (cyc >= 200000) begin
      tot_c++;
      tot_f++;
      $display("FAIL R6 watchdog actual=%0d expected<%0d", cyc, 200000);
    end
    $display("TB_RESULT checks=%0d failures=%0d", tot_c, tot_f);
    $finish;
  end

endmodule